// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block forms the second operand of a data-processing operation in a single cycle. A front end picks the operand's source: an immediate word that goes through untouched, or a register value shifted by an amount taken either from an immediate field or from the low byte of a second register. When the shifted register is the program counter, the front end adds the pipeline offset of the current instruction state before shifting.

The shifter core supports logical left, logical right, arithmetic right, rotate right, and a one-place rotate right through the carry flag. It returns the shifted word and the shifter carry-out. The result and the carry follow the usual processor rules for an amount of zero, for exactly the word width, and for amounts above the word width. The block has no clock and no state. Reading the register file and writing flags back are left to the surrounding datapath.

Top module: `shf_operand_unit`

## Requirements
- R1: For shift kinds 0 (left logical), 1 (right logical), 2 (right arithmetic) and 3 (rotate right), an amount of zero returns the source unchanged, and carry_out equals carry_in.
- R2: Kind 0 with an amount from 1 to 32 returns the source shifted left, with zeros entering at bit 0. carry_out is source bit (32 - amount), so an amount of 32 gives 0 with carry source bit 0.
- R3: Kind 0 or kind 1 with an amount above 32 returns 0, and carry_out is 0.
- R4: Kind 1 with an amount from 1 to 32 returns the source shifted right, with zeros entering at the top. carry_out is source bit (amount - 1).
- R5: Kind 2 with an amount from 1 to 32 fills the vacated top bits with source bit 31. carry_out is source bit (amount - 1), so an amount of 32 gives all sign bits with carry equal to the sign.
- R6: Kind 2 with an amount above 32 sets every result bit and carry_out to source bit 31.
- R7: Kind 3 with a non-zero amount rotates right by the amount modulo 32. carry_out equals bit 31 of the rotated result.
- R8: Kind 4 rotates right by one place through the carry: carry_in enters bit 31 and source bit 0 becomes carry_out. The amount has no effect.
- R9: Kind codes 5, 6 and 7 return the source unchanged, with carry_out equal to carry_in.
- R10: Only the low 8 bits of a register-supplied amount are used. An amount register holding 0x100 therefore acts as an amount of zero.
- R11: Operand select 0 outputs imm_val with carry_out equal to carry_in. Select 1 shifts reg_val by amt_imm. Selects 2 and 3 shift reg_val by the low byte of amt_reg.
- R12: When reg_is_pc is set in a register-operand select, the value shifted is reg_val + 8 if narrow_state is 0, and reg_val + 4 if narrow_state is 1.
- R13: The block is purely combinational, so result and carry_out follow the inputs in the same cycle. All-zero inputs give result 0 and carry_out 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operand source: 0 immediate, 1 register by immediate amount, 2/3 register by register amount |
| imm_val | input | 32 | Immediate operand word |
| reg_val | input | 32 | Value read from the register to be shifted |
| reg_is_pc | input | 1 | The shifted register is the program counter |
| narrow_state | input | 1 | 1 when executing 16-bit instructions, 0 for 32-bit |
| amt_imm | input | 8 | Shift amount from the instruction's immediate field |
| amt_reg | input | 32 | Register value whose low byte supplies the shift amount |
| shift_kind | input | 3 | Shift type code, 0 to 4 defined |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The assertions sit inside combinational blocks and are evaluated only after the inputs settle, so they assume every input holds a known 0/1 value and stays stable for at least part of each cycle. To meet this, the stimulus drives all inputs together, once per cycle, shortly after the rising edge, and never leaves a port undriven. Kind codes 5 to 7 are treated as legal inputs with a defined outcome, so the random phase draws the kind freely over all eight codes. It also draws the amount over the full byte, covering zero, 32 and the values above it.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [2:0] {
    SHK_LSL = 3'd0,
    SHK_LSR = 3'd1,
    SHK_ASR = 3'd2,
    SHK_ROR = 3'd3,
    SHK_RRX = 3'd4
  } shk_e;

  typedef enum logic [1:0] {
    OPS_IMM     = 2'd0,
    OPS_REG_IMM = 2'd1,
    OPS_REG_REG = 2'd2,
    OPS_REG_ALT = 2'd3
  } ops_e;

endpackage

// File: rtl/shf_operand_sel.sv
module shf_operand_sel #(
  parameter int DATA_W        = 32,
  parameter int AMT_W         = 8,
  parameter int PC_OFS_WIDE   = 8,
  parameter int PC_OFS_NARROW = 4
) (
  input  logic [1:0]        op_sel,
  input  logic [DATA_W-1:0] imm_val,
  input  logic [DATA_W-1:0] reg_val,
  input  logic              reg_is_pc,
  input  logic              narrow_state,
  input  logic [AMT_W-1:0]  amt_imm,
  input  logic [DATA_W-1:0] amt_reg,
  input  logic [2:0]        shift_kind,
  output logic [DATA_W-1:0] shift_src,
  output logic [AMT_W-1:0]  shift_amt,
  output logic [2:0]        kind_eff
);
  import shf_pkg::*;

  logic [DATA_W-1:0] pc_offset;
  logic [DATA_W-1:0] reg_adjusted;
  logic              unused_amt_hi;

  assign unused_amt_hi = ^amt_reg[DATA_W-1:AMT_W];

  // pipeline read-ahead of the program counter depends on instruction width
  assign pc_offset    = narrow_state ? DATA_W'(PC_OFS_NARROW) : DATA_W'(PC_OFS_WIDE);
  assign reg_adjusted = reg_is_pc ? (reg_val + pc_offset) : reg_val;

  always_comb begin
    unique case (op_sel)
      OPS_IMM: begin
        // an unshifted operand: left shift by zero leaves value and carry alone
        shift_src = imm_val;
        shift_amt = '0;
        kind_eff  = SHK_LSL;
      end
      OPS_REG_IMM: begin
        shift_src = reg_adjusted;
        shift_amt = amt_imm;
        kind_eff  = shift_kind;
      end
      default: begin
        shift_src = reg_adjusted;
        shift_amt = amt_reg[AMT_W-1:0];
        kind_eff  = shift_kind;
      end
    endcase
  end

endmodule

// File: rtl/shf_rotator.sv
module shf_rotator #(
  parameter int DATA_W = 32,
  localparam int ROT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [ROT_W-1:0]  amt,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stage [0:ROT_W];

  assign stage[0] = din;

  // logarithmic rotate-right: stage s rotates by 2**s when amt[s] is set
  for (genvar s = 0; s < ROT_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt[s]
      ? {stage[s][STEP-1:0], stage[s][DATA_W-1:STEP]}
      : stage[s];
  end

  assign dout = stage[ROT_W];

endmodule

// File: rtl/shf_core.sv
module shf_core #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int ROT_W = $clog2(DATA_W)
) (
  input  logic [2:0]        kind,
  input  logic [DATA_W-1:0] src,
  input  logic [AMT_W-1:0]  amt,
  input  logic              cin,
  output logic [DATA_W-1:0] result,
  output logic              cout
);
  import shf_pkg::*;

  function automatic logic [DATA_W-1:0] keep_low(input logic [AMT_W-1:0] n);
    return {DATA_W{1'b1}} >> n;
  endfunction

  function automatic logic [DATA_W-1:0] keep_high(input logic [AMT_W-1:0] n);
    return {DATA_W{1'b1}} << n;
  endfunction

  logic              amt_zero;
  logic              amt_over;
  logic              src_sign;
  logic [ROT_W-1:0]  amt_mod;
  logic [ROT_W-1:0]  rot_amt;
  logic [ROT_W-1:0]  below_idx;
  logic [DATA_W-1:0] rot_val;
  logic [DATA_W-1:0] low_mask;
  logic [DATA_W-1:0] high_mask;
  logic              kind_counted;

  assign amt_zero     = (amt == '0);
  assign amt_over     = (int'(amt) > DATA_W);
  assign src_sign     = src[DATA_W-1];
  assign amt_mod      = amt[ROT_W-1:0];
  assign below_idx    = amt_mod - ROT_W'(1);
  assign kind_counted = (kind <= SHK_ROR);
  assign low_mask     = keep_low(amt);
  assign high_mask    = keep_high(amt);

  // a left shift is a right rotate by the complement; the same index names
  // the last bit pushed out of the top
  assign rot_amt = (kind == SHK_LSL) ? (ROT_W'(0) - amt_mod) : amt_mod;

  shf_rotator #(.DATA_W(DATA_W)) u_rot (
    .din  (src),
    .amt  (rot_amt),
    .dout (rot_val)
  );

  always_comb begin
    result = src;
    cout   = cin;
    if (kind_counted && amt_zero) begin
      result = src;
      cout   = cin;
    end else begin
      case (kind)
        SHK_LSL: begin
          if (amt_over) begin
            result = '0;
            cout   = 1'b0;
          end else begin
            result = rot_val & high_mask;
            cout   = src[rot_amt];
          end
        end
        SHK_LSR: begin
          if (amt_over) begin
            result = '0;
            cout   = 1'b0;
          end else begin
            result = rot_val & low_mask;
            cout   = src[below_idx];
          end
        end
        SHK_ASR: begin
          if (amt_over) begin
            result = {DATA_W{src_sign}};
            cout   = src_sign;
          end else begin
            result = (rot_val & low_mask) | ({DATA_W{src_sign}} & ~low_mask);
            cout   = src[below_idx];
          end
        end
        SHK_ROR: begin
          result = rot_val;
          cout   = rot_val[DATA_W-1];
        end
        SHK_RRX: begin
          result = {cin, src[DATA_W-1:1]};
          cout   = src[0];
        end
        default: begin
          result = src;
          cout   = cin;
        end
      endcase
    end

    if (kind_counted && amt_zero)
      assert_zero_amt_R1: assert (result == src && cout == cin)
        else $error("zero amount altered operand");
    if ((kind == SHK_LSL || kind == SHK_LSR) && amt_over)
      assert_logic_over_R3: assert (result == '0 && !cout)
        else $error("logical shift past width not cleared");
    if (kind == SHK_ASR && amt_over)
      assert_asr_over_R6: assert (result == {DATA_W{src[DATA_W-1]}} && cout == src[DATA_W-1])
        else $error("arithmetic shift past width not sign filled");
    if (kind == SHK_ROR && !amt_zero)
      assert_ror_carry_R7: assert (cout == result[DATA_W-1])
        else $error("rotate carry differs from result top bit");
    if (kind == SHK_RRX)
      assert_rrx_R8: assert (result[DATA_W-2:0] == src[DATA_W-1:1]
                             && result[DATA_W-1] == cin && cout == src[0])
        else $error("rotate through carry wrong");
    if (kind > SHK_RRX)
      assert_undef_kind_R9: assert (result == src && cout == cin)
        else $error("undefined kind altered operand");
  end

endmodule

// File: rtl/shf_operand_unit.sv
module shf_operand_unit #(
  parameter int DATA_W        = 32,
  parameter int AMT_W         = 8,
  parameter int PC_OFS_WIDE   = 8,
  parameter int PC_OFS_NARROW = 4
) (
  input  logic [1:0]        op_sel,
  input  logic [DATA_W-1:0] imm_val,
  input  logic [DATA_W-1:0] reg_val,
  input  logic              reg_is_pc,
  input  logic              narrow_state,
  input  logic [AMT_W-1:0]  amt_imm,
  input  logic [DATA_W-1:0] amt_reg,
  input  logic [2:0]        shift_kind,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);
  import shf_pkg::*;

  logic [DATA_W-1:0] shift_src;
  logic [AMT_W-1:0]  shift_amt;
  logic [2:0]        kind_eff;

  shf_operand_sel #(
    .DATA_W        (DATA_W),
    .AMT_W         (AMT_W),
    .PC_OFS_WIDE   (PC_OFS_WIDE),
    .PC_OFS_NARROW (PC_OFS_NARROW)
  ) u_sel (
    .op_sel       (op_sel),
    .imm_val      (imm_val),
    .reg_val      (reg_val),
    .reg_is_pc    (reg_is_pc),
    .narrow_state (narrow_state),
    .amt_imm      (amt_imm),
    .amt_reg      (amt_reg),
    .shift_kind   (shift_kind),
    .shift_src    (shift_src),
    .shift_amt    (shift_amt),
    .kind_eff     (kind_eff)
  );

  shf_core #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W)
  ) u_core (
    .kind   (kind_eff),
    .src    (shift_src),
    .amt    (shift_amt),
    .cin    (carry_in),
    .result (result),
    .cout   (carry_out)
  );

  always_comb begin
    if (op_sel == OPS_IMM)
      assert_imm_pass_R11: assert (result == imm_val && carry_out == carry_in)
        else $error("immediate operand not passed through");
  end

endmodule

// File: tb/shf_operand_unit_test.sv
module shf_operand_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  op_sel = '0;
  logic [31:0] imm_val = '0;
  logic [31:0] reg_val = '0;
  logic        reg_is_pc = 1'b0;
  logic        narrow_state = 1'b0;
  logic [7:0]  amt_imm = '0;
  logic [31:0] amt_reg = '0;
  logic [2:0]  shift_kind = '0;
  logic        carry_in = 1'b0;
  logic [31:0] result;
  logic        carry_out;

  int n_run  = 0;
  int n_fail = 0;

  typedef struct {
    logic [31:0] res;
    logic        c;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;

  shf_operand_unit uut (
    .op_sel       (op_sel),
    .imm_val      (imm_val),
    .reg_val      (reg_val),
    .reg_is_pc    (reg_is_pc),
    .narrow_state (narrow_state),
    .amt_imm      (amt_imm),
    .amt_reg      (amt_reg),
    .shift_kind   (shift_kind),
    .carry_in     (carry_in),
    .result       (result),
    .carry_out    (carry_out)
  );

  // model built on wide arithmetic rather than a rotator
  function automatic logic [32:0] model(input logic [2:0] k, input logic [31:0] s,
                                        input int a, input logic ci);
    logic [63:0]        w;
    logic signed [63:0] sw;
    int                 aa;
    if (k > 3'd4) return {ci, s};
    if (k == 3'd4) return {s[0], ci, s[31:1]};
    if (a == 0) return {ci, s};
    case (k)
      3'd0: begin
        if (a > 32) return 33'd0;
        w = {32'd0, s} << a;
        return {w[32], w[31:0]};
      end
      3'd1: begin
        if (a > 32) return 33'd0;
        w = {s, 32'd0} >> a;
        return {w[31], w[63:32]};
      end
      3'd2: begin
        aa = (a > 32) ? 32 : a;
        sw = $signed({s, 32'd0}) >>> aa;
        return {sw[31], sw[63:32]};
      end
      default: begin
        w = {s, s} >> (a % 32);
        return {w[31], w[31:0]};
      end
    endcase
  endfunction

  task automatic drive(input logic [1:0] op, input logic [31:0] iv, input logic [31:0] rv,
                       input logic pc, input logic nar, input logic [7:0] ai,
                       input logic [31:0] ar, input logic [2:0] k, input logic ci,
                       input string tag);
    logic [31:0] src;
    logic [32:0] m;
    int          a;
    exp_t        e;
    @(posedge clk);
    #1;
    op_sel = op; imm_val = iv; reg_val = rv; reg_is_pc = pc; narrow_state = nar;
    amt_imm = ai; amt_reg = ar; shift_kind = k; carry_in = ci;
    src = pc ? (rv + (nar ? 32'd4 : 32'd8)) : rv;
    a = (op == 2'd1) ? int'(ai) : int'(ar % 256);
    if (op == 2'd0) m = {ci, iv};
    else m = model(k, src, a, ci);
    e.res = m[31:0];
    e.c   = m[32];
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: outputs settle within the cycle, compare at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if (result !== e.res || carry_out !== e.c) begin
        n_fail++;
        $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                 e.tag, result, carry_out, e.res, e.c);
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    n_fail++;
    $display("FAIL R13: watchdog expired, actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    // R13: reset-time values with all-zero inputs
    n_run++;
    if (result !== 32'd0 || carry_out !== 1'b0) begin
      n_fail++;
      $display("FAIL R13: result=%h carry=%b expected result=00000000 carry=0", result, carry_out);
    end
    rst = 1'b0;

    // R1 zero amount on counted kinds
    drive(2'd1, 0, 32'hA5A5_A5A5, 0, 0, 8'd0, 0, 3'd0, 1'b1, "R1 lsl0");
    drive(2'd1, 0, 32'h8000_0001, 0, 0, 8'd0, 0, 3'd3, 1'b0, "R1 ror0");
    drive(2'd1, 0, 32'h8000_0000, 0, 0, 8'd0, 0, 3'd2, 1'b1, "R1 asr0");
    // R2 left shift
    drive(2'd1, 0, 32'h8000_0001, 0, 0, 8'd1, 0, 3'd0, 1'b0, "R2 lsl1");
    drive(2'd1, 0, 32'h1234_5678, 0, 0, 8'd4, 0, 3'd0, 1'b0, "R2 lsl4");
    drive(2'd1, 0, 32'h0000_0001, 0, 0, 8'd32, 0, 3'd0, 1'b0, "R2 lsl32");
    // R3 past width
    drive(2'd1, 0, 32'hFFFF_FFFF, 0, 0, 8'd33, 0, 3'd0, 1'b1, "R3 lsl33");
    drive(2'd1, 0, 32'hFFFF_FFFF, 0, 0, 8'd200, 0, 3'd1, 1'b1, "R3 lsr200");
    // R4 right logical
    drive(2'd1, 0, 32'h0000_0003, 0, 0, 8'd1, 0, 3'd1, 1'b0, "R4 lsr1");
    drive(2'd1, 0, 32'h8000_0000, 0, 0, 8'd32, 0, 3'd1, 1'b0, "R4 lsr32");
    // R5 right arithmetic
    drive(2'd1, 0, 32'h8000_0010, 0, 0, 8'd4, 0, 3'd2, 1'b1, "R5 asr4");
    drive(2'd1, 0, 32'h8000_0000, 0, 0, 8'd32, 0, 3'd2, 1'b0, "R5 asr32");
    // R6 arithmetic past width
    drive(2'd1, 0, 32'h7FFF_FFFF, 0, 0, 8'd40, 0, 3'd2, 1'b1, "R6 asr40pos");
    drive(2'd1, 0, 32'h9000_0000, 0, 0, 8'd255, 0, 3'd2, 1'b0, "R6 asr255neg");
    // R7 rotate
    drive(2'd1, 0, 32'h1234_5678, 0, 0, 8'd8, 0, 3'd3, 1'b1, "R7 ror8");
    drive(2'd1, 0, 32'h0000_000F, 0, 0, 8'd36, 0, 3'd3, 1'b0, "R7 ror36");
    drive(2'd1, 0, 32'h8000_0000, 0, 0, 8'd32, 0, 3'd3, 1'b0, "R7 ror32");
    // R8 rotate through carry, amount ignored
    drive(2'd1, 0, 32'h0000_0003, 0, 0, 8'd7, 0, 3'd4, 1'b1, "R8 rrx amt7");
    drive(2'd1, 0, 32'h0000_0002, 0, 0, 8'd0, 0, 3'd4, 1'b0, "R8 rrx amt0");
    // R9 undefined kinds
    drive(2'd1, 0, 32'hCAFE_F00D, 0, 0, 8'd5, 0, 3'd5, 1'b1, "R9 kind5");
    drive(2'd2, 0, 32'hCAFE_F00D, 0, 0, 8'd0, 32'd9, 3'd7, 1'b0, "R9 kind7");
    // R10 register amount uses low byte
    drive(2'd2, 0, 32'h0000_0001, 0, 0, 8'd0, 32'h0000_0104, 3'd0, 1'b1, "R10 amt 0x104");
    drive(2'd2, 0, 32'h0000_00F1, 0, 0, 8'd0, 32'h0000_0100, 3'd1, 1'b1, "R10 amt 0x100");
    // R11 operand select
    drive(2'd0, 32'hDEAD_BEEF, 32'h1, 1, 0, 8'd3, 32'd5, 3'd1, 1'b1, "R11 imm");
    drive(2'd0, 32'h0000_0001, 32'h1, 0, 1, 8'd9, 32'd9, 3'd4, 1'b0, "R11 imm rrxkind");
    drive(2'd1, 32'hFFFF_FFFF, 32'h0000_0010, 0, 0, 8'd2, 32'd7, 3'd0, 1'b0, "R11 reg by imm");
    drive(2'd3, 32'hFFFF_FFFF, 32'h0000_0010, 0, 0, 8'd2, 32'd3, 3'd1, 1'b0, "R11 sel3 reg by reg");
    // R12 program counter read-ahead
    drive(2'd1, 0, 32'h0000_1000, 1, 0, 8'd0, 0, 3'd0, 1'b0, "R12 pc wide");
    drive(2'd1, 0, 32'h0000_1000, 1, 1, 8'd0, 0, 3'd0, 1'b0, "R12 pc narrow");
    drive(2'd2, 0, 32'hFFFF_FFFC, 1, 0, 8'd0, 32'd4, 3'd3, 1'b0, "R12 pc wrap ror");

    // R13 mixed patterns, one result per cycle
    for (int i = 0; i < 300; i++) begin
      drive(2'($urandom), $urandom, $urandom, 1'($urandom), 1'($urandom),
            8'($urandom), $urandom, 3'($urandom), 1'($urandom), "R13 mixed");
    end

    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule